// File: doc/BRIEF.md
# Serial Bit-Rate and Frame Timing Generator

This block sets the pace for an asynchronous serial port. Software stores two bytes through a small write port: a mode byte and a rate byte. From them the block derives two single-cycle enables. A sample enable runs sixteen times per bit. A bit enable runs once per bit period. The block also reports how many bit times one character frame occupies, counting the start, data, parity and stop bits. The transmit and receive shifters use these enables and the frame length. They are outside this block.

The bit period in input clocks is the product of three factors:
- a base divide of 32, or 16 when the half-base input is high;
- a prescale of 4 raised to the mode byte's clock-select field;
- the rate byte plus one.

Any accepted write clears all divider stages together, so the first period after a write has full length. While the transmitter or the receiver is enabled, writes to either byte are dropped. The timing then continues undisturbed.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the mode byte reads 0x00, the rate byte reads 0xFF and the frame length is 10. The first bit enable comes 8192 cycles after reset is released, and the first sample enable 512 cycles after it.
- R2: The bit period in clocks is base × 4^cks × (rate + 1). Here cks is mode bits 1:0 and rate is the stored rate byte.
- R3: The base divide is 32 when half_base is 0 and 16 when half_base is 1.
- R4: os_tick pulses every period/16 clocks. Exactly 16 of them fall in each bit period, and the 16th coincides with bit_tick.
- R5: frame_bits = (8 − mode bit 6) + mode bit 5 + (mode bit 3 + 1) + 1. Mode bit 6 reduces the data bits to seven. Mode bit 5 adds a parity bit. Mode bit 3 selects two stop bits.
- R6: An accepted write clears the dividers. The first bit_tick then comes exactly one full period after the write cycle, and the first os_tick one sample period after it.
- R7: While tx_en or rx_en is high, writes are ignored. Both bytes keep their values, the dividers are not cleared and tick spacing is unchanged.
- R8: bit_tick is high for exactly one cycle per period.
- R9: Mode bits 2, 4 and 7 are stored and read back on mode_q. They change neither the tick timing nor frame_bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write target: 0 = mode byte, 1 = rate byte |
| wr_data | input | 8 | Write data |
| tx_en | input | 1 | Transmitter running; locks writes |
| rx_en | input | 1 | Receiver running; locks writes |
| half_base | input | 1 | Selects base divide 16 instead of 32 |
| mode_q | output | 8 | Stored mode byte |
| rate_q | output | 8 | Stored rate byte |
| bit_tick | output | 1 | One-cycle enable per bit period |
| os_tick | output | 1 | One-cycle enable, 16 per bit period |
| frame_bits | output | 4 | Bit times per character frame |

## Verification
The assertions check four things on every cycle:
- a locked write leaves both bytes unchanged;
- an accepted rate write stores its data;
- no bit_tick follows directly after a write or after another bit_tick;
- the frame length stays within 9 to 12.

Exact period lengths need the bench's scenarios, since they span hundreds of cycles. These cover the product of base, prescale and rate, the count of sample enables per bit, the full-period latency after a reload, and the undisturbed spacing across a locked write.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RATE_W           = 8,
  parameter int OS_RATIO         = 16,
  parameter bit LOCK_WHEN_ACTIVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              half_base,
  output logic [7:0]        mode_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              bit_tick,
  output logic              os_tick,
  output logic [3:0]        frame_bits
);

  localparam int PRE_W = 8;
  localparam int OS_W  = $clog2(OS_RATIO);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATIO - 1);

  logic [PRE_W-1:0]  pre_cnt, pre_div, pre_last;
  logic [RATE_W-1:0] rate_cnt;
  logic [OS_W-1:0]   os_cnt;
  logic              locked, wr_ok, pre_hit;

  assign locked = LOCK_WHEN_ACTIVE && (tx_en || rx_en);
  assign wr_ok  = wr_en && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 8'h00;
      rate_q <= '1;
    end else if (wr_ok) begin
      if (wr_addr) rate_q <= wr_data[RATE_W-1:0];
      else         mode_q <= wr_data;
    end
  end

  assign pre_div  = (half_base ? PRE_W'(1) : PRE_W'(2)) << {mode_q[1:0], 1'b0};
  assign pre_last = pre_div - PRE_W'(1);
  assign pre_hit  = pre_cnt >= pre_last;
  assign os_tick  = pre_hit && (rate_cnt == rate_q);
  assign bit_tick = os_tick && (os_cnt == OS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      os_cnt   <= '0;
    end else if (wr_ok) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      os_cnt   <= '0;
    end else begin
      pre_cnt <= pre_hit ? '0 : pre_cnt + PRE_W'(1);
      if (pre_hit)
        rate_cnt <= (rate_cnt == rate_q) ? '0 : rate_cnt + RATE_W'(1);
      if (os_tick)
        os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + OS_W'(1);
    end
  end

  assign frame_bits = 4'd8 - 4'(mode_q[6]) + 4'(mode_q[5]) + 4'(mode_q[3]) + 4'd2;

  AST_RATE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && !tx_en && !rx_en) |=> rate_q == $past(wr_data[RATE_W-1:0])); // R2
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_en && !rx_en) |=> !bit_tick); // R6
  AST_BIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick); // R8
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bits >= 4'd9 && frame_bits <= 4'd12); // R5

  if (LOCK_WHEN_ACTIVE) begin : g_lock_chk
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (tx_en || rx_en)) |=> ($stable(mode_q) && $stable(rate_q))); // R7
  end

endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, tx_en = 1'b0, rx_en = 1'b0, half_base = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] mode_q, rate_q;
  logic bit_tick, os_tick;
  logic [3:0] frame_bits;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  baud_tick_gen dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_en(tx_en), .rx_en(rx_en), .half_base(half_base),
    .mode_q(mode_q), .rate_q(rate_q), .bit_tick(bit_tick), .os_tick(os_tick),
    .frame_bits(frame_bits));

  // {mode, rate, 3'b0, half, frame bits, period}
  localparam logic [39:0] VEC [0:5] = '{
    {8'h94, 8'd0, 3'b0, 1'b1, 4'd10, 16'd16},
    {8'h68, 8'd0, 3'b0, 1'b0, 4'd11, 16'd32},
    {8'h41, 8'd2, 3'b0, 1'b1, 4'd9,  16'd192},
    {8'h2A, 8'd1, 3'b0, 1'b0, 4'd12, 16'd1024},
    {8'h0B, 8'd0, 3'b0, 1'b1, 4'd11, 16'd1024},
    {8'h60, 8'd9, 3'b0, 1'b0, 4'd10, 16'd320}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_bit(output int n);
    n = 0;
    while (!bit_tick) begin @(negedge clk); n++; end
  endtask

  task automatic wait_os(output int n);
    n = 0;
    while (!os_tick) begin @(negedge clk); n++; end
  endtask

  task automatic next_period(output int n, output int os_n);
    n = 0; os_n = 0;
    do begin @(negedge clk); n++; if (os_tick) os_n++; end while (!bit_tick);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, os_n, p;
    repeat (3) @(negedge clk);
    chk("R1 mode reset", mode_q, 8'h00);
    chk("R1 rate reset", rate_q, 8'hFF);
    chk("R1 frame reset", frame_bits, 10);
    rst_n = 1'b1;
    wait_os(n);
    chk("R1 first os after reset", n, 511);
    wait_bit(p);
    chk("R1 first bit after reset", n + p, 8191);
    @(negedge clk);
    chk("R8 bit_tick one cycle", bit_tick, 0);

    for (int i = 0; i < 6; i++) begin
      p = int'(VEC[i][15:0]);
      half_base = VEC[i][20];
      do_write(1'b0, VEC[i][39:32]);
      do_write(1'b1, VEC[i][31:24]);
      chk("R9 mode readback", mode_q, int'(VEC[i][39:32]));
      chk("R2 rate readback", rate_q, int'(VEC[i][31:24]));
      chk("R5 frame bits", frame_bits, int'(VEC[i][19:16]));
      wait_os(n);
      chk("R6 first os after write", n, p / 16 - 1);
      wait_bit(n);
      chk("R6 first bit after write", n + p / 16 - 1, p - 1);
      next_period(n, os_n);
      chk("R2 R3 bit period", n, p);
      chk("R4 os per bit", os_n, 16);
    end

    // R9: reserved bits do not move timing or frame length
    half_base = 1'b1;
    do_write(1'b0, 8'h00);
    do_write(1'b1, 8'h00);
    chk("R9 frame with bits clear", frame_bits, 10);
    wait_bit(n);
    next_period(n, os_n);
    chk("R9 period with bits clear", n, 16);

    // R7: locked rate write, no reload
    rx_en = 1'b1;
    wait_bit(n);
    do_write(1'b1, 8'd5);
    chk("R7 rate kept", rate_q, 0);
    wait_bit(n);
    chk("R7 no reload spacing", n, 14);
    next_period(n, os_n);
    chk("R7 period kept", n, 16);
    rx_en = 1'b0; tx_en = 1'b1;
    do_write(1'b0, 8'h6B);
    chk("R7 mode kept by tx_en", mode_q, 8'h00);
    chk("R7 frame kept", frame_bits, 10);
    tx_en = 1'b0;
    wait_bit(n);
    do_write(1'b1, 8'd1);
    chk("R7 unlocked write taken", rate_q, 1);
    wait_bit(n);
    chk("R6 reload after unlock", n, 31);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule